// File: doc/BRIEF.md
# FPU State Save Sequencer

This block holds the architectural state of a floating-point unit: the control, status and tag words, the instruction and data pointers, the last opcode, and a stack of eight 80-bit registers. On a start pulse it first waits until every earlier floating-point operation has retired. It then streams a memory image of that state, one byte per handshake, to a byte-addressed write port. When the last byte has been accepted, it returns the environment words to their power-on values in the same clock edge.

The image begins with an environment section and continues with the register stack. The environment section is 14 bytes when `size32_i` is low and 28 bytes when it is high. The stack section is always 80 bytes.

Two checks can stop a save before any byte is written. If either control bit `cr_em_i` or `cr_ts_i` is set, the block raises a device-not-available fault. In the waiting variant (`wait_mode_i` high), a pending unmasked exception stops the save and is signalled instead. A separate synchronous clear aborts a save in progress and leaves the held state untouched.

The state is filled through a load port:
- When `ld_sel_i[3]` is 0, the load writes stack register `ld_sel_i[2:0]`.
- When `ld_sel_i[3]` is 1, `ld_sel_i[2:0]` picks an environment field: 0 control, 1 status, 2 tag, 3 instruction pointer, 4 data pointer, 5 opcode.

Top module: `fpu_state_saver`

## Requirements
- R1: While `mem_valid_o` is high, one byte moves on each cycle in which `mem_ready_i` is also high. The n-th byte goes to `base_addr_i + n`, with n running 0, 1, 2, … and no gap. During a cycle with ready low, the address and data stay unchanged.
- R2: The image length is set by `size32_i` as sampled at start: 94 bytes when it is 0, and 108 bytes when it is 1.
- R3: The environment is seven slots written in this order: control, status, tag, instruction pointer, opcode, data pointer, zero. Each slot is 2 bytes when `size32_i` is 0 and 4 bytes when it is 1, and each is written little-endian. A 2-byte slot holds the low 16 bits of its field. A 4-byte slot holds the full 32-bit pointers; the 16-bit words and the 11-bit opcode are zero-extended.
- R4: Stack register i occupies offsets E+10i to E+10i+9, where E is 14 or 28. The registers go in ascending order, and each is written little-endian.
- R5: Both reset (`rst_ni` low) and a completed save set control to 0x037F, status to 0, tag to 0xFFFF, and both pointers and the opcode to 0. After a save, `done_o` is high for exactly one cycle, and that cycle is the first one in which these values are visible. The stack registers are not altered by a completed save.
- R6: The status word, including its condition bits 8, 9, 10 and 14, is written to the image with the value it held. It reads 0 only after the save completes.
- R7: With `wait_mode_i` high and `exc_pending_i` high once the unit is idle, the block pulses `fp_exc_o` for one cycle. It writes no byte and changes no state.
- R8: With `wait_mode_i` low, `exc_pending_i` has no effect, and the full image is written.
- R9: If `cr_em_i` or `cr_ts_i` is high at start, the block pulses `dna_fault_o` for one cycle. It writes no byte, never goes busy, and changes no state.
- R10: No byte is written while `fpu_idle_i` is low. Loads made during that wait appear in the image. Loads made while bytes are being written are ignored.
- R11: A start pulse that arrives while `busy_o` is high is ignored. The save in progress completes with exactly one `done_o`, and no second save follows.
- R12: When `seq_clr_i` is high, the sequencer is idle on the next cycle, with no `done_o` and no reinitialisation. The held state is kept.
- R13: The load port updates the field chosen by `ld_sel_i`, using the encoding given above. The control, status and tag words are visible on `cw_o`, `sw_o` and `tw_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seq_clr_i | input | 1 | Synchronous abort of the sequencer |
| start_i | input | 1 | Start pulse |
| wait_mode_i | input | 1 | 1: check for a pending exception before saving |
| size32_i | input | 1 | 1: 32-bit image (108 bytes), 0: 16-bit image (94 bytes) |
| base_addr_i | input | ADDR_W | Image base address |
| cr_em_i | input | 1 | Coprocessor-emulate control bit |
| cr_ts_i | input | 1 | Task-switched control bit |
| fpu_idle_i | input | 1 | All earlier FP operations have retired |
| exc_pending_i | input | 1 | Unmasked FP exception pending |
| ld_en_i | input | 1 | State load strobe |
| ld_sel_i | input | SEL_W | Load target select |
| ld_data_i | input | REG_W | Load data |
| mem_valid_o | output | 1 | Write byte valid |
| mem_ready_i | input | 1 | Write byte accepted |
| mem_addr_o | output | ADDR_W | Write byte address |
| mem_data_o | output | 8 | Write byte data |
| busy_o | output | 1 | Save in progress |
| done_o | output | 1 | Save complete, state reinitialised |
| dna_fault_o | output | 1 | Device-not-available fault pulse |
| fp_exc_o | output | 1 | Pending exception signalled pulse |
| cw_o | output | 16 | Current control word |
| sw_o | output | 16 | Current status word |
| tw_o | output | 16 | Current tag word |

## Verification
The bench uses the default parameters: 32-bit addresses, eight stack registers, and 80-bit registers. This gives the exact image lengths of 94 and 108 bytes and the ten-byte register stride. The base address sits eight bytes below a 4 KiB boundary, so every image crosses the carry into bit 12 of the address. The ready pattern stalls one cycle in three, which exercises the hold-while-stalled rule in 32-bit mode.

// File: rtl/fsv_pkg.sv
package fsv_pkg;
  localparam int ENV_SLOTS = 7;
  localparam int OP_W      = 11;

  typedef struct packed {
    logic [15:0]     cw;
    logic [15:0]     sw;
    logic [15:0]     tw;
    logic [31:0]     ip;
    logic [31:0]     dp;
    logic [OP_W-1:0] op;
  } env_t;

  localparam env_t ENV_INIT = '{cw: 16'h037F, sw: 16'h0000, tw: 16'hFFFF,
                                ip: 32'h0, dp: 32'h0, op: '0};

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_DRAIN, SEQ_WRITE} seq_e;
endpackage

// File: rtl/fsv_state_regs.sv
module fsv_state_regs
  import fsv_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 80,
  parameter int SEL_W    = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [SEL_W-1:0]                wr_sel_i,
  input  logic [REG_W-1:0]                wr_data_i,
  input  logic                            reinit_i,
  output env_t                            env_o,
  output logic [NUM_REGS-1:0][REG_W-1:0]  stack_o
);
  env_t env_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      env_q <= ENV_INIT;
    end else if (reinit_i) begin
      env_q <= ENV_INIT;
    end else if (wr_en_i && wr_sel_i[SEL_W-1]) begin
      case (wr_sel_i[2:0])
        3'd0: env_q.cw <= wr_data_i[15:0];
        3'd1: env_q.sw <= wr_data_i[15:0];
        3'd2: env_q.tw <= wr_data_i[15:0];
        3'd3: env_q.ip <= wr_data_i[31:0];
        3'd4: env_q.dp <= wr_data_i[31:0];
        3'd5: env_q.op <= wr_data_i[OP_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_stack
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stack_o[g] <= '0;
      end else if (wr_en_i && !wr_sel_i[SEL_W-1] &&
                   wr_sel_i[SEL_W-2:0] == (SEL_W-1)'(g)) begin
        stack_o[g] <= wr_data_i;
      end
    end
  end

  assign env_o = env_q;
endmodule

// File: rtl/fsv_image_mux.sv
module fsv_image_mux
  import fsv_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 80,
  parameter int LIDX_W   = 3,
  parameter int IDX_W    = 3,
  parameter int BSEL_W   = 4
) (
  input  env_t                           env_i,
  input  logic [NUM_REGS-1:0][REG_W-1:0] stack_i,
  input  logic                           in_stack_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic [BSEL_W-1:0]              bsel_i,
  output logic [7:0]                     byte_o
);
  logic [31:0]      slot_w;
  logic [31:0]      slot_sh;
  logic [REG_W-1:0] reg_sh;

  // slot order: cw, sw, tw, ip, op, dp, zero
  always_comb begin
    case (idx_i)
      IDX_W'(0): slot_w = 32'(env_i.cw);
      IDX_W'(1): slot_w = 32'(env_i.sw);
      IDX_W'(2): slot_w = 32'(env_i.tw);
      IDX_W'(3): slot_w = env_i.ip;
      IDX_W'(4): slot_w = 32'(env_i.op);
      IDX_W'(5): slot_w = env_i.dp;
      default:   slot_w = '0;
    endcase
    slot_sh = slot_w >> {bsel_i, 3'b000};
    reg_sh  = stack_i[idx_i[LIDX_W-1:0]] >> {bsel_i, 3'b000};
    byte_o  = in_stack_i ? reg_sh[7:0] : slot_sh[7:0];
  end
endmodule

// File: rtl/fsv_ctrl.sv
module fsv_ctrl
  import fsv_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_REGS  = 8,
  parameter int REG_BYTES = 10,
  parameter int IDX_W     = 3,
  parameter int BSEL_W    = 4,
  parameter int OFF_W     = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seq_clr_i,
  input  logic              start_i,
  input  logic              wait_mode_i,
  input  logic              size32_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              cr_em_i,
  input  logic              cr_ts_i,
  input  logic              fpu_idle_i,
  input  logic              exc_pending_i,
  input  logic              mem_ready_i,
  output logic              mem_valid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              in_stack_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BSEL_W-1:0] bsel_o,
  output logic              reinit_o,
  output logic              writing_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              dna_fault_o,
  output logic              fp_exc_o
);
  seq_e              state_q;
  logic              s32_q, wait_q;
  logic [ADDR_W-1:0] base_q;
  logic [OFF_W-1:0]  off_q;
  logic              in_stack_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BSEL_W-1:0] bsel_q;
  logic              done_q, dna_q, exc_q;
  logic              fire, env_byte_end, env_end, reg_byte_end, stack_end;

  always_comb begin
    fire         = (state_q == SEQ_WRITE) && mem_ready_i && !seq_clr_i;
    env_byte_end = bsel_q == (s32_q ? BSEL_W'(3) : BSEL_W'(1));
    env_end      = env_byte_end && (idx_q == IDX_W'(ENV_SLOTS-1));
    reg_byte_end = bsel_q == BSEL_W'(REG_BYTES-1);
    stack_end    = reg_byte_end && (idx_q == IDX_W'(NUM_REGS-1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SEQ_IDLE;
      s32_q      <= 1'b0;
      wait_q     <= 1'b0;
      base_q     <= '0;
      off_q      <= '0;
      in_stack_q <= 1'b0;
      idx_q      <= '0;
      bsel_q     <= '0;
      done_q     <= 1'b0;
      dna_q      <= 1'b0;
      exc_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      dna_q  <= 1'b0;
      exc_q  <= 1'b0;
      if (seq_clr_i) begin
        state_q <= SEQ_IDLE;
      end else begin
        case (state_q)
          SEQ_IDLE: if (start_i) begin
            if (cr_em_i || cr_ts_i) begin
              dna_q <= 1'b1;
            end else begin
              state_q <= SEQ_DRAIN;
              s32_q   <= size32_i;
              wait_q  <= wait_mode_i;
              base_q  <= base_addr_i;
            end
          end
          SEQ_DRAIN: if (fpu_idle_i) begin
            if (wait_q && exc_pending_i) begin
              exc_q   <= 1'b1;
              state_q <= SEQ_IDLE;
            end else begin
              state_q    <= SEQ_WRITE;
              off_q      <= '0;
              in_stack_q <= 1'b0;
              idx_q      <= '0;
              bsel_q     <= '0;
            end
          end
          SEQ_WRITE: if (fire) begin
            off_q <= off_q + 1'b1;
            if (!in_stack_q) begin
              if (env_end) begin
                bsel_q     <= '0;
                idx_q      <= '0;
                in_stack_q <= 1'b1;
              end else if (env_byte_end) begin
                bsel_q <= '0;
                idx_q  <= idx_q + 1'b1;
              end else begin
                bsel_q <= bsel_q + 1'b1;
              end
            end else if (stack_end) begin
              state_q <= SEQ_IDLE;
              done_q  <= 1'b1;
            end else if (reg_byte_end) begin
              bsel_q <= '0;
              idx_q  <= idx_q + 1'b1;
            end else begin
              bsel_q <= bsel_q + 1'b1;
            end
          end
          default: state_q <= SEQ_IDLE;
        endcase
      end
    end
  end

  assign mem_valid_o = state_q == SEQ_WRITE;
  assign mem_addr_o  = base_q + ADDR_W'(off_q);
  assign in_stack_o  = in_stack_q;
  assign idx_o       = idx_q;
  assign bsel_o      = bsel_q;
  assign reinit_o    = fire && in_stack_q && stack_end;
  assign writing_o   = state_q == SEQ_WRITE;
  assign busy_o      = state_q != SEQ_IDLE;
  assign done_o      = done_q;
  assign dna_fault_o = dna_q;
  assign fp_exc_o    = exc_q;
endmodule

// File: rtl/fpu_state_saver.sv
module fpu_state_saver
  import fsv_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 80,
  localparam int REG_BYTES = REG_W / 8,
  localparam int LIDX_W    = $clog2(NUM_REGS),
  localparam int IDX_W     = (LIDX_W > 3) ? LIDX_W : 3,
  localparam int SEL_W     = IDX_W + 1,
  localparam int BSEL_W    = ($clog2(REG_BYTES) > 2) ? $clog2(REG_BYTES) : 2,
  localparam int MAX_BYTES = 4 * ENV_SLOTS + NUM_REGS * REG_BYTES,
  localparam int OFF_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seq_clr_i,
  input  logic              start_i,
  input  logic              wait_mode_i,
  input  logic              size32_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              cr_em_i,
  input  logic              cr_ts_i,
  input  logic              fpu_idle_i,
  input  logic              exc_pending_i,
  input  logic              ld_en_i,
  input  logic [SEL_W-1:0]  ld_sel_i,
  input  logic [REG_W-1:0]  ld_data_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              dna_fault_o,
  output logic              fp_exc_o,
  output logic [15:0]       cw_o,
  output logic [15:0]       sw_o,
  output logic [15:0]       tw_o
);
  env_t                           env;
  logic [NUM_REGS-1:0][REG_W-1:0] stack;
  logic                           in_stack, reinit, writing;
  logic [IDX_W-1:0]               idx;
  logic [BSEL_W-1:0]              bsel;

  fsv_ctrl #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES),
    .IDX_W(IDX_W), .BSEL_W(BSEL_W), .OFF_W(OFF_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .seq_clr_i, .start_i, .wait_mode_i, .size32_i,
    .base_addr_i, .cr_em_i, .cr_ts_i, .fpu_idle_i, .exc_pending_i,
    .mem_ready_i, .mem_valid_o, .mem_addr_o,
    .in_stack_o(in_stack), .idx_o(idx), .bsel_o(bsel),
    .reinit_o(reinit), .writing_o(writing),
    .busy_o, .done_o, .dna_fault_o, .fp_exc_o
  );

  // loads frozen while bytes stream so the image stays coherent
  fsv_state_regs #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(ld_en_i && !writing), .wr_sel_i(ld_sel_i), .wr_data_i(ld_data_i),
    .reinit_i(reinit), .env_o(env), .stack_o(stack)
  );

  fsv_image_mux #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .LIDX_W(LIDX_W),
    .IDX_W(IDX_W), .BSEL_W(BSEL_W)
  ) u_mux (
    .env_i(env), .stack_i(stack), .in_stack_i(in_stack),
    .idx_i(idx), .bsel_i(bsel), .byte_o(mem_data_o)
  );

  assign cw_o = env.cw;
  assign sw_o = env.sw;
  assign tw_o = env.tw;
endmodule

// File: rtl/fsv_checker.sv
module fsv_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              seq_clr_i,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [7:0]        mem_data_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              dna_fault_o,
  input logic              fp_exc_o,
  input logic [15:0]       cw_o,
  input logic [15:0]       sw_o,
  input logic [15:0]       tw_o
);
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i && !seq_clr_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o))); // R1
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_ready_i && !seq_clr_i) |=>
      (!mem_valid_o || mem_addr_o == $past(mem_addr_o) + 1'b1)); // R1
  AST_DONE_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cw_o == 16'h037F && sw_o == 16'h0 && tw_o == 16'hFFFF)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_EXC_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_exc_o |-> (!mem_valid_o && !busy_o)); // R7
  AST_FAULT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dna_fault_o |-> (!mem_valid_o && !busy_o)); // R9
  AST_CLR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_clr_i |=> (!busy_o && !mem_valid_o && !done_o)); // R12
endmodule

bind fpu_state_saver fsv_checker #(.ADDR_W(ADDR_W)) u_fsv_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .seq_clr_i(seq_clr_i),
  .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
  .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .busy_o(busy_o),
  .done_o(done_o), .dna_fault_o(dna_fault_o), .fp_exc_o(fp_exc_o),
  .cw_o(cw_o), .sw_o(sw_o), .tw_o(tw_o)
);

// File: tb/fpu_state_saver_test.sv
`timescale 1ns/1ps
module fpu_state_saver_test;
  localparam logic [31:0] BASE = 32'h0000_0FF8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        seq_clr_i = 1'b0, start_i = 1'b0, wait_mode_i = 1'b0, size32_i = 1'b0;
  logic [31:0] base_addr_i = BASE;
  logic        cr_em_i = 1'b0, cr_ts_i = 1'b0, fpu_idle_i = 1'b1, exc_pending_i = 1'b0;
  logic        ld_en_i = 1'b0;
  logic [3:0]  ld_sel_i = '0;
  logic [79:0] ld_data_i = '0;
  logic        mem_valid_o, mem_ready_i = 1'b1;
  logic [31:0] mem_addr_o;
  logic [7:0]  mem_data_o;
  logic        busy_o, done_o, dna_fault_o, fp_exc_o;
  logic [15:0] cw_o, sw_o, tw_o;

  fpu_state_saver uut (
    .clk_i(clk), .rst_ni, .seq_clr_i, .start_i, .wait_mode_i, .size32_i,
    .base_addr_i, .cr_em_i, .cr_ts_i, .fpu_idle_i, .exc_pending_i,
    .ld_en_i, .ld_sel_i, .ld_data_i, .mem_valid_o, .mem_ready_i,
    .mem_addr_o, .mem_data_o, .busy_o, .done_o, .dna_fault_o, .fp_exc_o,
    .cw_o, .sw_o, .tw_o
  );

  always #2 clk = ~clk;  // 250 MHz

  int checks = 0, failures = 0, cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // bench model of held state
  logic [15:0] m_cw, m_sw, m_tw;
  logic [31:0] m_ip, m_dp;
  logic [10:0] m_op;
  logic [79:0] m_st [8];

  logic [7:0] cap [128];
  int         cnt, done_cnt, extra;
  bit         addr_ok, tail_busy;
  logic [15:0] done_cw, done_sw, done_tw;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int off, bit s32);
    int w;
    int el;
    int rel;
    logic [31:0] v;
    logic [31:0] t;
    logic [79:0] s;
    w  = s32 ? 4 : 2;
    el = 7 * w;
    if (off < el) begin
      case (off / w)
        0: v = {16'h0, m_cw};
        1: v = {16'h0, m_sw};
        2: v = {16'h0, m_tw};
        3: v = m_ip;
        4: v = {21'h0, m_op};
        5: v = m_dp;
        default: v = '0;
      endcase
      t = v >> (8 * (off % w));
      return t[7:0];
    end
    rel = off - el;
    s = m_st[rel / 10] >> (8 * (rel % 10));
    return s[7:0];
  endfunction

  function automatic void model_reinit();
    m_cw = 16'h037F; m_sw = 16'h0; m_tw = 16'hFFFF;
    m_ip = '0; m_dp = '0; m_op = '0;
  endfunction

  task automatic ld(logic [3:0] sel, logic [79:0] d);
    @(negedge clk);
    ld_en_i = 1'b1; ld_sel_i = sel; ld_data_i = d;
    @(negedge clk);
    ld_en_i = 1'b0;
  endtask

  task automatic load_env(logic [15:0] cw, logic [15:0] sw, logic [15:0] tw,
                          logic [31:0] ip, logic [31:0] dp, logic [10:0] op);
    ld(4'h8, 80'(cw)); ld(4'h9, 80'(sw)); ld(4'hA, 80'(tw));
    ld(4'hB, 80'(ip)); ld(4'hC, 80'(dp)); ld(4'hD, 80'(op));
    m_cw = cw; m_sw = sw; m_tw = tw; m_ip = ip; m_dp = dp; m_op = op;
  endtask

  // act: 0 none, 1 extra start, 2 stack load, 3 seq clear; fired once nexp==act_at
  task automatic run_save(bit s32, bit wm, bit thr, int act_at, int act);
    int  nexp;
    bit  fired;
    bit  pend;
    nexp = 0; fired = 0; pend = 0;
    done_cnt = 0; extra = 0; addr_ok = 1; tail_busy = 0;
    @(negedge clk);
    size32_i = s32; wait_mode_i = wm; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 600; k++) begin
      if (pend) begin
        start_i = 1'b0; seq_clr_i = 1'b0; ld_en_i = 1'b0; pend = 0;
      end
      mem_ready_i = thr ? (k % 3 != 1) : 1'b1;
      if (mem_valid_o && mem_ready_i) begin
        if (mem_addr_o != BASE + 32'(nexp)) addr_ok = 0;
        if (nexp < 128) cap[nexp] = mem_data_o;
        nexp++;
      end
      if (done_o) begin
        done_cnt++;
        done_cw = cw_o; done_sw = sw_o; done_tw = tw_o;
        break;
      end
      if (!fired && act != 0 && nexp == act_at) begin
        fired = 1; pend = 1;
        case (act)
          1: start_i = 1'b1;
          2: begin ld_en_i = 1'b1; ld_sel_i = 4'h0; ld_data_i = '1; end
          default: seq_clr_i = 1'b1;
        endcase
      end
      @(negedge clk);
    end
    start_i = 1'b0; seq_clr_i = 1'b0; ld_en_i = 1'b0; mem_ready_i = 1'b1;
    cnt = nexp;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k == 0 && busy_o) tail_busy = 1;
      if (mem_valid_o || done_o) extra++;
    end
  endtask

  task automatic chk_image(bit s32, string env_req, string stk_req);
    int el;
    int total;
    int env_bad;
    int stk_bad;
    logic [7:0] ea, ee, sa, se;
    el = s32 ? 28 : 14;
    total = el + 80;
    env_bad = 0; stk_bad = 0;
    ea = '0; ee = '0; sa = '0; se = '0;
    for (int o = 0; o < total; o++) begin
      if (cap[o] !== exp_byte(o, s32)) begin
        if (o < el) begin
          if (env_bad == 0) begin ea = cap[o]; ee = exp_byte(o, s32); end
          env_bad++;
        end else begin
          if (stk_bad == 0) begin sa = cap[o]; se = exp_byte(o, s32); end
          stk_bad++;
        end
      end
    end
    chk(env_bad == 0, env_req, ea, ee);
    chk(stk_bad == 0, stk_req, sa, se);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cw_o == 16'h037F && sw_o == 16'h0 && tw_o == 16'hFFFF, "R5 reset words",
        {cw_o, sw_o, tw_o}, 48'h037F_0000_FFFF);
    chk(!busy_o && !mem_valid_o && !done_o, "R5 reset idle",
        {busy_o, mem_valid_o, done_o}, 0);
  endtask

  task automatic t_load_and_save16();
    for (int i = 0; i < 8; i++) begin
      m_st[i] = {16'hC000 + 16'(i), 64'h0123_4567_89AB_CDEF + 64'(i * 32'h1111_0101)};
      ld(4'(i), m_st[i]);
    end
    load_env(16'h027F, 16'h47A5, 16'h5A0F, 32'h89AB_CDEF, 32'h1357_9BDF, 11'h5C3);
    chk(cw_o == 16'h027F && sw_o == 16'h47A5 && tw_o == 16'h5A0F, "R13 load port",
        {cw_o, sw_o, tw_o}, 48'h027F_47A5_5A0F);
    run_save(1'b0, 1'b0, 1'b0, 0, 0);
    chk(cnt == 94, "R2 16-bit length", cnt, 94);
    chk(addr_ok, "R1 address sequence", addr_ok, 1);
    chk_image(1'b0, "R3 env 16-bit", "R4 stack 16-bit");
    chk({cap[3], cap[2]} == 16'h47A5, "R6 condition bits saved", {cap[3], cap[2]}, 16'h47A5);
    chk(done_cnt == 1 && extra == 0, "R5 done pulse", done_cnt * 10 + extra, 10);
    chk(done_cw == 16'h037F && done_sw == 16'h0 && done_tw == 16'hFFFF,
        "R5 reinit at done", {done_cw, done_sw, done_tw}, 48'h037F_0000_FFFF);
    chk(sw_o == 16'h0, "R6 status cleared after", sw_o, 0);
    model_reinit();
  endtask

  task automatic t_reinit_image();
    run_save(1'b0, 1'b0, 1'b0, 0, 0);
    chk_image(1'b0, "R5 reinit env image", "R5 stack untouched");
  endtask

  task automatic t_save32();
    load_env(16'h0A7F, 16'h3800, 16'h00FF, 32'h89AB_CDEF, 32'hFEDC_1234, 11'h7FF);
    run_save(1'b1, 1'b0, 1'b1, 0, 0);
    chk(cnt == 108, "R2 32-bit length", cnt, 108);
    chk(addr_ok, "R1 address under stalls", addr_ok, 1);
    chk_image(1'b1, "R3 env 32-bit", "R4 stack 32-bit");
    model_reinit();
  endtask

  task automatic t_exc();
    int nexc;
    int nval;
    load_env(16'h0123, 16'h0080, 16'h0000, 32'h1, 32'h2, 11'h3);
    exc_pending_i = 1'b1;
    nexc = 0; nval = 0;
    @(negedge clk);
    wait_mode_i = 1'b1; size32_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (fp_exc_o) nexc++;
      if (mem_valid_o) nval++;
      @(negedge clk);
    end
    chk(nexc == 1 && nval == 0, "R7 exception stops save", nexc * 10 + nval, 10);
    chk(cw_o == 16'h0123 && !busy_o, "R7 state kept", cw_o, 16'h0123);
    run_save(1'b0, 1'b0, 1'b0, 0, 0);
    chk(cnt == 94 && done_cnt == 1, "R8 no-wait ignores pending", cnt, 94);
    chk_image(1'b0, "R8 env image", "R8 stack image");
    model_reinit();
    exc_pending_i = 1'b0;
  endtask

  task automatic t_fault(bit em, bit ts, string req);
    int ndna;
    int nval;
    int nbusy;
    ld(4'h8, 80'h0222);
    m_cw = 16'h0222;
    ndna = 0; nval = 0; nbusy = 0;
    cr_em_i = em; cr_ts_i = ts;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (dna_fault_o) ndna++;
      if (mem_valid_o) nval++;
      if (busy_o) nbusy++;
      @(negedge clk);
    end
    cr_em_i = 1'b0; cr_ts_i = 1'b0;
    chk(ndna == 1 && nval == 0 && nbusy == 0, req, ndna * 100 + nval * 10 + nbusy, 100);
    chk(cw_o == 16'h0222, req, cw_o, 16'h0222);
  endtask

  task automatic t_drain();
    bit early;
    early = 0;
    fpu_idle_i = 1'b0;
    fork
      run_save(1'b0, 1'b0, 1'b0, 20, 2);
      begin
        repeat (8) @(negedge clk);
        if (mem_valid_o || !busy_o) early = 1;
        ld(4'h9, 80'h0100);
        m_sw = 16'h0100;
        fpu_idle_i = 1'b1;
      end
    join
    chk(!early, "R10 waits for idle", early, 0);
    chk(cnt == 94, "R10 length after drain", cnt, 94);
    chk({cap[3], cap[2]} == 16'h0100, "R10 load during wait in image",
        {cap[3], cap[2]}, 16'h0100);
    model_reinit();
    run_save(1'b0, 1'b0, 1'b0, 0, 0);
    chk_image(1'b0, "R10 env next image", "R10 load during write ignored");
  endtask

  task automatic t_restart();
    run_save(1'b0, 1'b0, 1'b0, 30, 1);
    chk(cnt == 94 && done_cnt == 1, "R11 busy start ignored", cnt, 94);
    chk(extra == 0 && !tail_busy, "R11 no second save", extra, 0);
  endtask

  task automatic t_clear();
    ld(4'h8, 80'h0321);
    m_cw = 16'h0321;
    run_save(1'b0, 1'b0, 1'b0, 10, 3);
    chk(done_cnt == 0 && extra == 0 && !tail_busy, "R12 clear idles",
        done_cnt * 10 + extra, 0);
    chk(cw_o == 16'h0321, "R12 state kept", cw_o, 16'h0321);
    run_save(1'b0, 1'b0, 1'b0, 0, 0);
    chk(cnt == 94 && done_cnt == 1, "R12 save after clear", cnt, 94);
    model_reinit();
  endtask

  initial begin
    model_reinit();
    for (int i = 0; i < 8; i++) m_st[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_load_and_save16();
    t_reinit_image();
    t_save32();
    t_exc();
    t_fault(1'b1, 1'b0, "R9 emulate bit fault");
    t_fault(1'b0, 1'b1, "R9 task-switched fault");
    t_drain();
    t_restart();
    t_clear();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule